// File: doc/BRIEF.md
# Descriptor-List Buffer Mover

This block copies a linear local buffer to host memory, or host memory into the buffer, by following a list of region descriptors held in host memory. Each descriptor names a host region (a 64-bit base address) and its size. The mover fills or drains regions one after another. From each region it takes the smaller of the region size and the bytes still owed, then moves on to the next descriptor.

A walk starts with a one-cycle `start` pulse that carries the list base address, the byte length, the number of descriptors and the direction. The walk ends when the owed bytes reach zero or the descriptors run out, whichever comes first. At that point `done` pulses for one cycle and `moved` holds the number of bytes actually transferred. This count can be less than the requested length.

The block has three ports:
- a descriptor read port, one 32-bit word per request;
- a word-wide host memory port, with byte enables for a partial last word;
- a local buffer port with one-cycle read latency.

Each port carries one request at a time.

Top module: `sg_walker`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `dsc_req`, `mem_req` and `buf_en` are low, and `moved` is 0.
- R2: Descriptor layout and fetch order:
  - Descriptor k sits at `list_base + 16*k`, and `list_base` is 16-byte aligned.
  - The word at +0 is address bits [31:0] and the word at +4 is address bits [63:32]. These words are read in that order.
  - The word at +12 holds the byte-count field in bits [21:0]. Bits [31:22] of that word are ignored.
  - The word at +8 is never read.
  - Memory beats of a region use the 64-bit base with bits [1:0] cleared.
- R3: The region size is the byte-count field plus one. The chunk taken from a region is min(region size, bytes still owed).
- R4: Memory beats are word-aligned and the address rises by 4 per beat. A beat with 4 or more chunk bytes left uses byte enable 4'b1111. A final beat with n bytes left (n = 1..3) enables the low n lanes (4'b0001, 4'b0011, 4'b0111).
- R5: The buffer word index starts at 0 for each walk and advances by one per beat, across descriptors. A chunk of c bytes therefore consumes ceil(c/4) buffer words, and buffer bytes past the chunk's end within its last word are not touched.
- R6: With `dir_to_buf` = 0, buffer words are read and written to memory. With `dir_to_buf` = 1, memory words are read and written to the buffer, using the same byte enables.
- R7: The walk stops once the owed bytes reach zero. Descriptors after that point are not fetched.
- R8: The walk stops after the last descriptor. `moved` then reports the bytes actually moved, which is less than the requested length.
- R9: A start with length 0 or descriptor count 0 completes with `moved` = 0 and no descriptor or memory access.
- R10: `done` is a single-cycle pulse at the end of every walk. `moved` holds its value until the next accepted start. A `start` while busy is ignored.
- R11: At most one of the descriptor, memory and buffer ports is active in a cycle. A descriptor or memory request holds its address and controls stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| dir_to_buf | input | 1 | 1: memory to buffer, 0: buffer to memory |
| list_base | input | ADDR_W | Descriptor list base address |
| xfer_len | input | LEN_W | Requested byte length |
| desc_num | input | CNT_W | Number of descriptors in the list |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| moved | output | LEN_W | Bytes moved by the last walk |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | ADDR_W | Descriptor word address |
| dsc_ack | input | 1 | Descriptor read acknowledge, data valid |
| dsc_rdata | input | 32 | Descriptor word |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |
| buf_en | output | 1 | Buffer access enable |
| buf_we | output | 1 | Buffer write (1) or read (0) |
| buf_addr | output | BUF_AW | Buffer word index |
| buf_be | output | 4 | Buffer byte enables |
| buf_wdata | output | 32 | Buffer write data |
| buf_rdata | input | 32 | Buffer read data, one cycle after a read |

## Verification
The assertions check the following on every cycle:
- the request handshake rules: one port at a time, and stable requests until acknowledged;
- word alignment and the legal byte-enable shapes;
- that the reserved descriptor word is never addressed;
- the one-cycle `done` pulse and a quiet idle state;
- that `moved` never exceeds the requested length.

Only the bench scenarios show the following:
- that chunk clamping, region-size decoding and the two stop conditions give the right byte counts;
- that data lands at the right memory and buffer bytes while neighbouring bytes stay untouched;
- that a start while busy leaves the walk unchanged.

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 24,
  parameter int CNT_W  = 16,
  parameter int BUF_AW = 6,
  parameter int SZ_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_to_buf,
  input  logic [ADDR_W-1:0] list_base,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [CNT_W-1:0]  desc_num,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  moved,
  output logic              dsc_req,
  output logic [ADDR_W-1:0] dsc_addr,
  input  logic              dsc_ack,
  input  logic [31:0]       dsc_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              buf_en,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [3:0]        buf_be,
  output logic [31:0]       buf_wdata,
  input  logic [31:0]       buf_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_BUFRD, S_BUFCAP, S_MEM, S_BUFWR, S_DONE
  } state_t;

  state_t             st;
  logic               dir_q;
  logic [LEN_W-1:0]   rem, cl;
  logic [CNT_W-1:0]   left;
  logic [ADDR_W-1:0]  ptr, maddr;
  logic [1:0]         widx;
  logic [31:2]        lo_q;
  logic [BUF_AW-1:0]  bw;
  logic [31:0]        dreg;

  logic [LEN_W-1:0]   sz_ext, bb;
  logic [3:0]         beat_be;
  logic [63:0]        base64;
  logic               fire, chunk_end;

  assign sz_ext    = LEN_W'(dsc_rdata[SZ_W-1:0]) + LEN_W'(1);
  assign base64    = {dsc_rdata, lo_q, 2'b00};
  assign bb        = (cl >= LEN_W'(4)) ? LEN_W'(4) : cl;
  assign beat_be   = (cl >= LEN_W'(4)) ? 4'hF : ((4'b0001 << cl[1:0]) - 4'd1);
  assign fire      = (st == S_MEM && mem_ack && !dir_q) || (st == S_BUFWR);
  assign chunk_end = (cl == bb);

  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);
  assign dsc_req   = (st == S_FETCH);
  assign dsc_addr  = ptr + ADDR_W'({widx, 2'b00});
  assign mem_req   = (st == S_MEM);
  assign mem_we    = !dir_q;
  assign mem_addr  = maddr;
  assign mem_be    = beat_be;
  assign mem_wdata = dreg;
  assign buf_en    = (st == S_BUFRD) || (st == S_BUFWR);
  assign buf_we    = (st == S_BUFWR);
  assign buf_addr  = bw;
  assign buf_be    = beat_be;
  assign buf_wdata = dreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      dir_q <= 1'b0;
      rem   <= '0;
      cl    <= '0;
      left  <= '0;
      ptr   <= '0;
      maddr <= '0;
      widx  <= '0;
      lo_q  <= '0;
      bw    <= '0;
      dreg  <= '0;
      moved <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          st <= S_IDLE;
          if (start) begin
            dir_q <= dir_to_buf;
            rem   <= xfer_len;
            left  <= desc_num;
            ptr   <= list_base;
            widx  <= 2'd0;
            bw    <= '0;
            moved <= '0;
            st    <= (xfer_len == '0 || desc_num == '0) ? S_DONE : S_FETCH;
          end
        end
        S_FETCH: if (dsc_ack) begin
          case (widx)
            2'd0:    begin lo_q <= dsc_rdata[31:2]; widx <= 2'd1; end
            2'd1:    begin maddr <= base64[ADDR_W-1:0]; widx <= 2'd3; end
            default: begin
              cl   <= (sz_ext < rem) ? sz_ext : rem;
              widx <= 2'd0;
              st   <= dir_q ? S_MEM : S_BUFRD;
            end
          endcase
        end
        S_BUFRD:  st <= S_BUFCAP;
        S_BUFCAP: begin dreg <= buf_rdata; st <= S_MEM; end
        S_MEM: if (mem_ack && dir_q) begin
          dreg <= mem_rdata;
          st   <= S_BUFWR;
        end
        default: ;
      endcase

      if (fire) begin
        cl    <= cl - bb;
        rem   <= rem - bb;
        moved <= moved + bb;
        bw    <= bw + BUF_AW'(1);
        maddr <= maddr + ADDR_W'(4);
        if (chunk_end) begin
          left <= left - CNT_W'(1);
          ptr  <= ptr + ADDR_W'(16);
          st   <= (rem == bb || left == CNT_W'(1)) ? S_DONE : S_FETCH;
        end else begin
          st <= dir_q ? S_MEM : S_BUFRD;
        end
      end
    end
  end

endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [LEN_W-1:0]  xfer_len,
  input logic [LEN_W-1:0]  moved,
  input logic              dsc_req,
  input logic              dsc_ack,
  input logic [ADDR_W-1:0] dsc_addr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              buf_en
);

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) len_q <= '0;
    else if (start && !busy) len_q <= xfer_len;
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dsc_req && !mem_req && !buf_en));

  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dsc_req, mem_req, buf_en}));

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be)));

  a_r11_dsc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_addr)));

  a_r4_beat_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 &&
                 (mem_be == 4'b1111 || mem_be == 4'b0111 || mem_be == 4'b0011 || mem_be == 4'b0001)));

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_req |-> (dsc_addr[3:2] != 2'b10));

  a_r8_moved_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (moved <= len_q));

endmodule

bind sg_walker sg_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_sg_walker.sv
`timescale 1ns/1ps
module test_sg_walker;
  localparam int AW = 64, LW = 24, CW = 16, BAW = 6;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, dir_to_buf = 0;
  logic [AW-1:0] list_base = 64'h800;
  logic [LW-1:0] xfer_len = '0;
  logic [CW-1:0] desc_num = '0;
  logic busy, done;
  logic [LW-1:0] moved;
  logic dsc_req, dsc_ack;
  logic [AW-1:0] dsc_addr;
  logic [31:0] dsc_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be, buf_be;
  logic [31:0] mem_wdata, mem_rdata, buf_wdata, buf_rdata;
  logic buf_en, buf_we;
  logic [BAW-1:0] buf_addr;

  sg_walker i_sg_walker (.*);

  logic [31:0] mem [0:1023];
  logic [31:0] bufm [0:63];
  int checks = 0, fails = 0;
  int fetch_cnt = 0, rsv_cnt = 0, done_cnt = 0, hi_bad = 0, viol = 0;
  logic [31:0] exp_hi = 0;
  logic prev_mpend = 0, prev_dpend = 0;
  logic [AW-1:0] prev_maddr, prev_daddr;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; dsc_ack <= 0; mem_rdata <= 0; dsc_rdata <= 0; buf_rdata <= 0;
      prev_mpend <= 0; prev_dpend <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      dsc_ack <= dsc_req && !dsc_ack;
      if (mem_req && !mem_ack) begin
        if (mem_addr[63:32] != exp_hi) hi_bad <= hi_bad + 1;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[11:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
        end else mem_rdata <= mem[mem_addr[11:2]];
      end
      if (dsc_req && !dsc_ack) begin
        dsc_rdata <= mem[dsc_addr[11:2]];
        fetch_cnt <= fetch_cnt + 1;
        if (dsc_addr[3:2] == 2'b10) rsv_cnt <= rsv_cnt + 1;
      end
      if (buf_en) begin
        if (buf_we) begin
          for (int k = 0; k < 4; k++)
            if (buf_be[k]) bufm[buf_addr][8*k +: 8] <= buf_wdata[8*k +: 8];
        end else buf_rdata <= bufm[buf_addr];
      end
      if (done) done_cnt <= done_cnt + 1;
      if (prev_mpend && (!mem_req || mem_addr != prev_maddr)) viol <= viol + 1;
      if (prev_dpend && (!dsc_req || dsc_addr != prev_daddr)) viol <= viol + 1;
      if ({1'b0, dsc_req} + {1'b0, mem_req} + {1'b0, buf_en} > 2'd1) viol <= viol + 1;
      prev_mpend <= mem_req && !mem_ack;
      prev_dpend <= dsc_req && !dsc_ack;
      prev_maddr <= mem_addr;
      prev_daddr <= dsc_addr;
    end
  end

  function automatic logic [7:0] mpat(input int a); return 8'((a * 13 + 1) & 255); endfunction
  function automatic logic [7:0] bpat(input int b); return 8'((b * 7 + 64) & 255); endfunction
  function automatic logic [7:0] mbyte(input int a); return mem[a >> 2][8*(a % 4) +: 8]; endfunction
  function automatic logic [7:0] bbyte(input int b); return bufm[b >> 2][8*(b % 4) +: 8]; endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic init_data();
    for (int i = 0; i < 512; i++)
      for (int k = 0; k < 4; k++) mem[i][8*k +: 8] = mpat(i * 4 + k);
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 4; k++) bufm[i][8*k +: 8] = bpat(i * 4 + k);
  endtask

  task automatic set_desc(input int k, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] w3);
    mem[512 + 4*k]     = lo;
    mem[512 + 4*k + 1] = hi;
    mem[512 + 4*k + 2] = 32'hDEADBEEF;
    mem[512 + 4*k + 3] = w3;
  endtask

  task automatic launch(input bit d, input int len, input int n);
    @(negedge clk);
    fetch_cnt = 0; rsv_cnt = 0; done_cnt = 0; hi_bad = 0;
    dir_to_buf = d; xfer_len = LW'(len); desc_num = CW'(n); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, "R10 walk ends", t, 3000);
    @(negedge clk);
  endtask

  int bad;

  task automatic t_reset();
    check(!busy && !done && !dsc_req && !mem_req && !buf_en, "R1 idle outputs",
          {busy, done, dsc_req, mem_req, buf_en}, 0);
    check(moved == 0, "R1 moved", moved, 0);
  endtask

  task automatic t_two_regions_to_mem();
    init_data();
    set_desc(0, 32'h100, 0, 32'hFFC0000F);
    set_desc(1, 32'h200, 0, 32'h7);
    launch(0, 24, 2);
    wait_done();
    bad = 0;
    for (int i = 0; i < 16; i++) if (mbyte(32'h100 + i) != bpat(i)) bad++;
    for (int i = 0; i < 8; i++)  if (mbyte(32'h200 + i) != bpat(16 + i)) bad++;
    check(bad == 0, "R6 R2 buffer to memory data", bad, 0);
    check(mbyte(32'h210) == mpat(32'h210) && mbyte(32'h110) == mpat(32'h110), "R3 neighbours untouched", 0, 0);
    check(moved == 24, "R2 moved with ignored high bits", moved, 24);
    check(fetch_cnt == 6 && rsv_cnt == 0, "R2 fetched words", fetch_cnt * 100 + rsv_cnt, 600);
    check(done_cnt == 1, "R10 done pulse", done_cnt, 1);
    repeat (5) @(negedge clk);
    check(moved == 24, "R10 moved held", moved, 24);
  endtask

  task automatic t_clamp();
    init_data();
    set_desc(0, 32'h300, 0, 32'hF);
    set_desc(1, 32'h340, 0, 32'hF);
    set_desc(2, 32'h380, 0, 32'hF);
    launch(0, 10, 3);
    wait_done();
    bad = 0;
    for (int i = 0; i < 10; i++) if (mbyte(32'h300 + i) != bpat(i)) bad++;
    check(bad == 0, "R3 clamped chunk data", bad, 0);
    bad = 0;
    for (int i = 10; i < 16; i++) if (mbyte(32'h300 + i) != mpat(32'h300 + i)) bad++;
    check(bad == 0, "R4 partial byte enables", bad, 0);
    check(moved == 10, "R3 moved clamped", moved, 10);
    check(fetch_cnt == 3, "R7 later descriptors not fetched", fetch_cnt, 3);
    check(mbyte(32'h340) == mpat(32'h340), "R7 second region untouched", mbyte(32'h340), mpat(32'h340));
  endtask

  task automatic t_runout_to_buf();
    init_data();
    set_desc(0, 32'h040, 0, 32'h7);
    set_desc(1, 32'h080, 0, 32'hB);
    launch(1, 100, 2);
    wait_done();
    bad = 0;
    for (int i = 0; i < 8; i++)  if (bbyte(i) != mpat(32'h40 + i)) bad++;
    for (int i = 0; i < 12; i++) if (bbyte(8 + i) != mpat(32'h80 + i)) bad++;
    check(bad == 0, "R6 memory to buffer data", bad, 0);
    check(bufm[5] == {bpat(23), bpat(22), bpat(21), bpat(20)}, "R8 buffer past end untouched", bufm[5], 0);
    check(moved == 20, "R8 moved short of length", moved, 20);
    check(done_cnt == 1, "R8 single done", done_cnt, 1);
  endtask

  task automatic t_odd_chunk();
    init_data();
    set_desc(0, 32'h0C0, 0, 32'h5);
    set_desc(1, 32'h0E0, 0, 32'h7);
    launch(1, 14, 2);
    wait_done();
    bad = 0;
    for (int i = 0; i < 6; i++) if (bbyte(i) != mpat(32'hC0 + i)) bad++;
    for (int i = 0; i < 8; i++) if (bbyte(8 + i) != mpat(32'hE0 + i)) bad++;
    check(bad == 0, "R5 next chunk starts on next buffer word", bad, 0);
    check(bbyte(6) == bpat(6) && bbyte(7) == bpat(7), "R5 R4 tail lanes untouched",
          {bbyte(7), bbyte(6)}, {bpat(7), bpat(6)});
    check(moved == 14, "R3 moved odd", moved, 14);
  endtask

  task automatic t_empty();
    launch(0, 0, 2);
    wait_done();
    check(moved == 0 && fetch_cnt == 0 && done_cnt == 1, "R9 zero length",
          moved * 100 + fetch_cnt * 10 + done_cnt, 1);
    launch(1, 8, 0);
    wait_done();
    check(moved == 0 && fetch_cnt == 0 && done_cnt == 1, "R9 zero count",
          moved * 100 + fetch_cnt * 10 + done_cnt, 1);
  endtask

  task automatic t_start_busy();
    init_data();
    set_desc(0, 32'h380, 0, 32'h7);
    launch(0, 8, 1);
    repeat (3) @(negedge clk);
    xfer_len = 0; desc_num = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    bad = 0;
    for (int i = 0; i < 8; i++) if (mbyte(32'h380 + i) != bpat(i)) bad++;
    check(bad == 0 && moved == 8, "R10 start while busy ignored", moved, 8);
    check(done_cnt == 1, "R10 one done", done_cnt, 1);
  endtask

  task automatic t_high_addr();
    init_data();
    exp_hi = 32'h1;
    set_desc(0, 32'h3C1, 32'h1, 32'h3);
    launch(0, 4, 1);
    wait_done();
    check(hi_bad == 0, "R2 high address word used", hi_bad, 0);
    check(mbyte(32'h3C0) == bpat(0) && mbyte(32'h3C3) == bpat(3), "R2 low bits cleared", mbyte(32'h3C0), bpat(0));
    exp_hi = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    init_data();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_two_regions_to_mem();
    t_clamp();
    t_runout_to_buf();
    t_odd_chunk();
    t_empty();
    t_start_busy();
    t_high_addr();
    check(viol == 0, "R11 handshake and single port", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule